// File: doc/BRIEF.md
# 8x8 Two-Dimensional DCT Engine

This block takes one 8x8 tile of signed 8-bit picture samples and returns its 2-D discrete cosine transform as 64 signed 12-bit coefficients. It uses the separable method. Every row of the tile goes through a 1-D DCT. The intermediate matrix is transposed. The same 1-D DCT is then applied again, which transforms the columns. Each 1-D pass multiplies the data directly by a fixed cosine matrix held as scaled signed integers, and one shared dot-product unit carries out both passes.

Samples arrive on a valid-qualified stream in row-major order. Once the 64th sample is in, the block runs through fixed phases in this order: load the working matrix, row pass, column pass, store, and emit. The coefficients leave as one unbroken run of 64 valid cycles, DC first. While a tile is being processed, the input stream is not observed. Immediately after the last coefficient has been emitted, the block can accept the next tile.

Top module: `dct2d_block`

## Requirements
- R1: During synchronous active-low reset, and in the first cycle after it, `out_valid` is low and the block waits for samples.
- R2: A sample is taken only in a cycle with `in_valid` high. Cycles with `in_valid` low may fall anywhere between samples and do not change the result. Samples are two's complement and fill the tile in row-major order: sample i is row i/8, column i%8.
- R3: Each tile gives exactly 64 consecutive cycles of `out_valid` high, and `out_valid` is low in the cycle after the last of them.
- R4: Coefficient k of the output run is X(u,v) with u = k/8 (vertical frequency) and v = k%8 (horizontal frequency), so the DC term comes first. Each coefficient is within ±2 of the real-valued orthonormal DCT-II X(u,v) = a(u)a(v)·Σ s(y,x)·cos((2y+1)uπ/16)·cos((2x+1)vπ/16), where a(0)=√(1/8) and a(n>0)=1/2. The output is signed 12-bit two's complement.
- R5: The first coefficient appears 130 clock edges after the edge that accepts the 64th sample. Phase lengths are fixed: 1 load cycle, 64 row cycles, 64 column cycles, 1 store cycle.
- R6: Anything presented on the input from the edge that accepts the 64th sample until the last coefficient has been emitted is ignored. It affects neither the current tile nor the next one.
- R7: A sample presented in the cycle right after the last valid coefficient is accepted as the first sample of the next tile. No state carries over from one tile to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | 8 | Signed picture sample |
| out_valid | output | 1 | Qualifies `out_coef` |
| out_coef | output | 12 | Signed DCT coefficient |

## Verification
The bench builds the block with tile size 8, 16-bit intermediates, 12-bit outputs and 12 fractional bits in the cosine constants. With that precision, full-scale constant tiles at +127 and −128 stay inside the ±2 window of the real-valued reference. Coarser constants would drift well past that window at the DC term. The reference DCT is computed in real arithmetic in the bench and is applied to constant, ramp, checkerboard, single-impulse and pseudo-random tiles. Some tiles are delivered with idle gaps, and junk samples are driven throughout processing and output, so that the latency, the 64-cycle output run, the ignored input and back-to-back acceptance are all observed at the ports.

// File: rtl/dct2d_pkg.sv
// Shared types for the 2-D DCT engine.
// Assumes: phases are visited strictly in the listed order.
package dct2d_pkg;

    typedef enum logic [2:0] {
        PH_CAPTURE,  // collecting the tile
        PH_LOAD,     // copy capture buffer into working matrix
        PH_ROW,      // 1-D pass over rows, written transposed
        PH_COL,      // same 1-D pass again, written transposed back
        PH_STORE,    // clip and move into output buffer
        PH_OUT       // stream coefficients
    } dct2d_phase_e;

endpackage

// File: rtl/dct2d_dot.sv
// One output element of a 1-D DCT: dot product of an N-element data row
// with row `sel_i` of the scaled cosine basis, rounded half-up to remove
// the 2^FRAC scale and saturated to RW signed bits.
// Assumes: purely combinational; caller registers the result.
module dct2d_dot #(
    parameter int N    = 8,
    parameter int DW   = 16,
    parameter int FRAC = 12,
    parameter int RW   = 16,
    localparam int SEL_W = $clog2(N)
) (
    input  logic [N*DW-1:0]  vec_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [RW-1:0]    res_o
);

    localparam int  CW    = FRAC + 2;
    localparam int  ACC_W = DW + CW + SEL_W + 1;
    localparam real PI    = 3.14159265358979323846;

    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] R_MAX = ACC_W'((64'sd1 <<< (RW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] R_MIN = -R_MAX - 1;

    // Builds the cosine basis as CW-bit signed constants scaled by 2^FRAC.
    function automatic logic [N*N*CW-1:0] build_basis();
        logic [N*N*CW-1:0] t;
        real amp, val;
        int  q;
        t = '0;
        for (int u = 0; u < N; u++) begin
            for (int k = 0; k < N; k++) begin
                amp = (u == 0) ? $sqrt(1.0 / N) : $sqrt(2.0 / N);
                val = amp * $cos(PI * real'((2 * k + 1) * u) / real'(2 * N))
                      * real'(64'd1 << FRAC);
                q = (val >= 0.0) ? $rtoi(val + 0.5) : -$rtoi(0.5 - val);
                t[(u * N + k) * CW +: CW] = q[CW-1:0];
            end
        end
        return t;
    endfunction

    localparam logic [N*N*CW-1:0] BASIS = build_basis();

    logic signed [DW-1:0]    term_d;
    logic signed [CW-1:0]    term_c;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;

    // Multiply-accumulate across the row, then round and clip.
    always_comb begin
        acc = '0;
        for (int k = 0; k < N; k++) begin
            term_d = vec_i[k*DW +: DW];
            term_c = BASIS[(int'(sel_i) * N + k) * CW +: CW];
            acc    = acc + term_d * term_c;
        end
        scaled = (acc + HALF) >>> FRAC;
        if (scaled > R_MAX)      res_o = R_MAX[RW-1:0];
        else if (scaled < R_MIN) res_o = R_MIN[RW-1:0];
        else                     res_o = scaled[RW-1:0];
    end

endmodule

// File: rtl/dct2d_seq.sv
// Phase sequencer for the 2-D DCT engine. Steps a shared element index
// through capture, load, row pass, column pass, store and output.
// Assumes: capture advances only on in_valid; every other phase ignores it.
module dct2d_seq
    import dct2d_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N * N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output dct2d_phase_e       phase_o,
    output logic [IDX_W-1:0]   idx_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N * N - 1);

    dct2d_phase_e      phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_inc;

    assign idx_inc = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    assign phase_o = phase_q;
    assign idx_o   = idx_q;

    // Phase and index register: advance per phase rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CAPTURE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_CAPTURE: if (in_valid) begin
                    idx_q <= idx_inc;
                    if (idx_q == LAST) phase_q <= PH_LOAD;
                end
                PH_LOAD: begin
                    idx_q   <= '0;
                    phase_q <= PH_ROW;
                end
                PH_ROW: begin
                    idx_q <= idx_inc;
                    if (idx_q == LAST) phase_q <= PH_COL;
                end
                PH_COL: begin
                    idx_q <= idx_inc;
                    if (idx_q == LAST) phase_q <= PH_STORE;
                end
                PH_STORE: begin
                    idx_q   <= '0;
                    phase_q <= PH_OUT;
                end
                PH_OUT: begin
                    idx_q <= idx_inc;
                    if (idx_q == LAST) phase_q <= PH_CAPTURE;
                end
                default: phase_q <= PH_CAPTURE;
            endcase
        end
    end

    // R2: no sample slot is consumed while in_valid is low
    assert_hold_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CAPTURE && !in_valid) |=> $stable(idx_q));

    // R3: output run continues until its last element, then ends
    assert_out_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_OUT && idx_q != LAST) |=> phase_q == PH_OUT);
    assert_out_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_OUT && idx_q == LAST) |=> phase_q == PH_CAPTURE);

    // R5: single-cycle load and store phases with fixed successors
    assert_load_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_LOAD |=> (phase_q == PH_ROW && idx_q == '0));
    assert_store_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_STORE |=> (phase_q == PH_OUT && idx_q == '0));

    // R6: processing phases advance every cycle whatever the input does
    assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ROW || phase_q == PH_COL || phase_q == PH_OUT)
        |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

endmodule

// File: rtl/dct2d_block.sv
// 8x8 2-D DCT engine. Buffers a tile, runs a 1-D DCT over the rows
// writing transposed, runs the same 1-D DCT again writing transposed
// back, clips to OUT_W bits and streams the result row-major, DC first.
// Assumes: one tile in flight; input ignored outside the capture phase.
module dct2d_block
    import dct2d_pkg::*;
#(
    parameter int N        = 8,
    parameter int IN_W     = 8,
    parameter int MID_W    = 16,
    parameter int OUT_W    = 12,
    parameter int COS_FRAC = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_coef
);

    localparam int NN    = N * N;
    localparam int IDX_W = $clog2(NN);
    localparam int LG    = $clog2(N);

    dct2d_phase_e     phase;
    logic [IDX_W-1:0] idx;
    logic [LG-1:0]    cur_row;
    logic [LG-1:0]    cur_freq;
    logic [IDX_W-1:0] wr_addr;

    logic [IN_W-1:0]  cap_mem [NN];
    logic [MID_W-1:0] mat_a   [NN];
    logic [MID_W-1:0] mat_b   [NN];
    logic [OUT_W-1:0] out_mem [NN];

    logic [N*MID_W-1:0] row_vec;
    logic [MID_W-1:0]   dot_res;

    // Clips an intermediate to the signed output range.
    function automatic logic [OUT_W-1:0] clip_out(input logic signed [MID_W-1:0] x);
        logic signed [MID_W-1:0] hi;
        logic signed [MID_W-1:0] lo;
        hi = MID_W'((32'sd1 <<< (OUT_W - 1)) - 1);
        lo = -hi - 1;
        if (x > hi)      return hi[OUT_W-1:0];
        else if (x < lo) return lo[OUT_W-1:0];
        else             return x[OUT_W-1:0];
    endfunction

    dct2d_seq #(.N(N)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .phase_o  (phase),
        .idx_o    (idx)
    );

    assign cur_row  = idx[IDX_W-1:LG];
    assign cur_freq = idx[LG-1:0];
    assign wr_addr  = {cur_freq, cur_row};

    // Select the data row for the active pass.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            row_vec[k*MID_W +: MID_W] = (phase == PH_COL) ? mat_b[int'(cur_row) * N + k]
                                                          : mat_a[int'(cur_row) * N + k];
        end
    end

    dct2d_dot #(
        .N    (N),
        .DW   (MID_W),
        .FRAC (COS_FRAC),
        .RW   (MID_W)
    ) u_dot (
        .vec_i (row_vec),
        .sel_i (cur_freq),
        .res_o (dot_res)
    );

    // Datapath storage: capture, load, both passes (transposed writes), store.
    always_ff @(posedge clk) begin
        unique case (phase)
            PH_CAPTURE: if (in_valid) cap_mem[idx] <= in_sample;
            PH_LOAD: for (int i = 0; i < NN; i++)
                mat_a[i] <= {{(MID_W - IN_W){cap_mem[i][IN_W-1]}}, cap_mem[i]};
            PH_ROW:   mat_b[wr_addr] <= dot_res;
            PH_COL:   mat_a[wr_addr] <= dot_res;
            PH_STORE: for (int i = 0; i < NN; i++)
                out_mem[i] <= clip_out(mat_a[i]);
            default: ;
        endcase
    end

    assign out_valid = (phase == PH_OUT);
    assign out_coef  = out_mem[idx];

    // R1: first cycle after reset release shows no output
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R4: every output run starts at the DC coefficient
    assert_dc_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> idx == '0);

endmodule

// File: tb/dct2d_block_test.sv
// Bench for dct2d_block: real-valued reference DCT, per-cycle comparison.
module dct2d_block_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int NN         = N * N;
    localparam int LATENCY    = 2 * NN + 3;
    localparam real PI        = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_sample = '0;
    logic        out_valid;
    logic [11:0] out_coef;

    int  total = 0;
    int  bad = 0;
    int  samp [NN];
    real expv [NN];
    int  lfsr = 16'hACE1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dct2d_block #(
        .N(N), .IN_W(8), .MID_W(16), .OUT_W(12), .COS_FRAC(12)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_coef  (out_coef)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void compute_ref();
        real au, av, acc;
        for (int u = 0; u < N; u++) begin
            for (int v = 0; v < N; v++) begin
                au = (u == 0) ? $sqrt(1.0 / 8.0) : 0.5;
                av = (v == 0) ? $sqrt(1.0 / 8.0) : 0.5;
                acc = 0.0;
                for (int y = 0; y < N; y++)
                    for (int x = 0; x < N; x++)
                        acc += real'(samp[y * N + x])
                             * $cos(real'((2 * y + 1) * u) * PI / 16.0)
                             * $cos(real'((2 * x + 1) * v) * PI / 16.0);
                expv[u * N + v] = au * av * acc;
            end
        end
    endfunction

    function automatic void fill(input int pat);
        for (int i = 0; i < NN; i++) begin
            case (pat)
                0: samp[i] = 127;
                1: samp[i] = -128;
                2: samp[i] = i * 4 - 128;
                3: samp[i] = (((i / N) + (i % N)) % 2 == 0) ? 100 : -100;
                4: begin
                    lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
                    samp[i] = (lfsr & 255) - 128;
                end
                default: samp[i] = (i == 3 * N + 5) ? 120 : 0;
            endcase
        end
    endfunction

    // Feeds one tile, then checks latency, output run and values.
    task automatic run_block(input int pat, input int gap_every, input string req);
        int cnt;
        int act;
        int expi;
        real diff;
        fill(pat);
        compute_ref();
        for (int i = 0; i < NN; i++) begin
            if (gap_every > 0 && (i % gap_every) == 1) begin
                in_valid  = 1'b0;
                in_sample = 8'h5A;
                @(negedge clk);
            end
            in_valid  = 1'b1;
            in_sample = samp[i][7:0];
            @(negedge clk);
        end
        cnt = 1;
        in_valid = 1'b1;
        in_sample = 8'h81;
        while (!out_valid && cnt < 1000) begin
            @(negedge clk);
            cnt++;
            in_sample = cnt[7:0];
        end
        check(cnt == LATENCY, "R5", "latency", cnt, LATENCY);
        for (int k = 0; k < NN; k++) begin
            if (k > 0) @(negedge clk);
            in_sample = 8'(k * 37);
            check(out_valid == 1'b1, "R3", "valid in run", int'(out_valid), 1);
            act  = int'($signed(out_coef));
            diff = real'(act) - expv[k];
            expi = (expv[k] >= 0.0) ? $rtoi(expv[k] + 0.5) : -$rtoi(0.5 - expv[k]);
            check(diff <= 2.0 && diff >= -2.0, req, "coefficient", act, expi);
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R3", "valid after run", int'(out_valid), 0);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
        run_block(0, 0, "R4");
        run_block(1, 0, "R4 R7");
        run_block(2, 5, "R2");
        run_block(3, 0, "R6 R7");
        run_block(4, 3, "R2 R6");
        run_block(5, 0, "R4 R7");
        finish_run();
    end

endmodule